// File: doc/BRIEF.md
# Four-Channel Prescaled Interval Timer

This block holds four independent down-counting interval timers behind a simple word-addressed register bus with a write strobe, an address, write data and a combinational read-data return. Each channel has a control word, an interval register and a read-only live count. An enabled channel decrements its count on every tick of its own power-of-two prescaler. When the count steps from 1 to 0 the channel raises its bit in a shared pending word.

Software clears a pending bit by writing 1 to it. A global enable word masks the pending bits onto a single interrupt line. A channel either runs continuously, reloading its interval after reaching zero, or runs once and then turns its own enable off. A reload strobe in the control word loads the interval into the count at once. This lets software start a channel from a known value.

Register layout: byte offset 0x00 is the interrupt enable word and 0x04 is the pending word. Channel n (0 to 3) uses a block at 0x10 + 0x10*n. Within that block, +0x0 is control, +0x4 is the interval and +0x8 is the live count. Addresses with bits [1:0] not zero, and offsets that are not mapped, read as 0 and ignore writes.

Top module: `multi_interval_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Control bit 0 enables a channel. While it is enabled, each prescaled tick lowers the live count (+0x8) by one, as long as the count is not zero.
- R3: Control bits [6:4] select the prescale. Codes 0 to 4 give one tick every 1, 2, 4, 8 or 16 clocks. Codes 5 to 7 also give one tick every 16 clocks.
- R4: When control bit 7 is 0 (continuous), a tick that arrives while the count is 0 loads the interval into the count. An interval of N therefore expires once every N+1 ticks.
- R5: A tick that takes the count from 1 to 0 sets pending bit n of channel n in the word at 0x04. The bit then stays set until software clears it.
- R6: When control bit 7 is 1 (single), the expiry also clears the channel's enable bit. The count then stays at 0.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If a clear and an expiry of the same bit happen in the same cycle, the bit stays set.
- R8: `irq_o` is high exactly when some pending bit is set and its bit in the enable word at 0x00 (bits [3:0]) is also set.
- R9: Writing control with bit 1 set copies the interval into the count on that same edge. Bit 1 always reads back as 0.
- R10: The prescaler restarts its division from zero when a control write turns the enable on or changes the prescale code.
- R11: Writes to the live count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register bus |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a software clear of a pending bit in exactly the cycle in which that channel expires. From the ports this depends on the prescaler phase and the count phase lining up with a bus write. The stimulus runs a channel at divide-by-one with a short interval and holds a clear write on the pending word for many consecutive cycles, so every expiry lands on a clear. A second hard case is a prescale change in the middle of a division. For that, a channel is left partway through a divide-by-eight period and then switched to divide-by-four, and the bench checks when the next tick arrives. A behavioural model compares the read data and the interrupt line on every clock.

// File: rtl/itv_pkg.sv
`timescale 1ns/1ps
package itv_pkg;
  localparam int unsigned PSC_W        = 3;
  localparam int unsigned MAX_DIV_LOG2 = 4;
  localparam int unsigned CTL_EN       = 0;
  localparam int unsigned CTL_RLD      = 1;
  localparam int unsigned CTL_PSC_LSB  = 4;
  localparam int unsigned CTL_MODE     = 7;

  localparam logic [1:0] SUB_CTRL = 2'd0;
  localparam logic [1:0] SUB_IVAL = 2'd1;
  localparam logic [1:0] SUB_CNT  = 2'd2;

  localparam logic [1:0] GLB_IER  = 2'd0;
  localparam logic [1:0] GLB_PEND = 2'd1;

  typedef struct packed {
    logic             single;
    logic [PSC_W-1:0] psc;
    logic             en;
  } itv_ctrl_t;
endpackage

// File: rtl/itv_prescaler.sv
`timescale 1ns/1ps
module itv_prescaler
  import itv_pkg::*;
#(
  parameter int unsigned MAX_LOG2 = MAX_DIV_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] code_i,
  output logic             tick_o
);
  localparam int unsigned PW = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] limit;

  always_comb begin
    int unsigned sh;
    sh    = (int'(code_i) > int'(MAX_LOG2)) ? MAX_LOG2 : int'(code_i);
    limit = PW'((32'd1 << sh) - 32'd1);
  end

  assign tick_o = en_i && (pre_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pre_q <= '0;
    else if (restart_i || !en_i || tick_o) pre_q <= '0;
    else                                  pre_q <= pre_q + 1'b1;
  end

  // back-to-back ticks only at divide-by-one
  assert_div1_back_to_back_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(tick_o)) |-> (code_i == '0));

  // after restart, no tick in the next cycle unless dividing by one
  assert_restart_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!tick_o || code_i == '0));
endmodule

// File: rtl/itv_channel.sv
`timescale 1ns/1ps
module itv_channel
  import itv_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              ival_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output itv_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  ival_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              expire_o
);
  itv_ctrl_t        ctrl_q, ctrl_new;
  logic [CNT_W-1:0] ival_q, cnt_q;
  logic             tick, restart, reload;

  always_comb begin
    ctrl_new.en     = wdata_i[CTL_EN];
    ctrl_new.psc    = wdata_i[CTL_PSC_LSB +: PSC_W];
    ctrl_new.single = wdata_i[CTL_MODE];
  end

  assign restart  = ctrl_we_i && ((ctrl_new.en && !ctrl_q.en) || (ctrl_new.psc != ctrl_q.psc));
  assign reload   = ctrl_we_i && wdata_i[CTL_RLD];
  assign expire_o = tick && (cnt_q == CNT_W'(1));

  itv_prescaler #(.MAX_LOG2(MAX_DIV_LOG2)) i_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (ctrl_q.en),
    .restart_i(restart),
    .code_i   (ctrl_q.psc),
    .tick_o   (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ctrl_q    <= '0;
    else if (ctrl_we_i)                   ctrl_q    <= ctrl_new;
    else if (expire_o && ctrl_q.single)   ctrl_q.en <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ival_q <= '0;
    else if (ival_we_i) ival_q <= wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (reload) cnt_q <= ival_q;
    else if (tick)   cnt_q <= (cnt_q == '0) ? ival_q : cnt_q - 1'b1;
  end

  assign ctrl_o = ctrl_q;
  assign ival_o = ival_q;
  assign cnt_o  = cnt_q;

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_continuous_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !reload && cnt_q == '0) |=> (cnt_q == $past(ival_q)));

  assert_single_disarms_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && ctrl_q.single && !ctrl_we_i) |=> !ctrl_q.en);

  assert_reload_copies_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> (cnt_q == $past(ival_q)));
endmodule

// File: rtl/multi_interval_timer.sv
`timescale 1ns/1ps
module multi_interval_timer
  import itv_pkg::*;
#(
  parameter int unsigned N_TMR  = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0] blk;
  logic [1:0]       sub;
  logic             word_ok, glb_wr;
  logic [N_TMR-1:0] ctrl_we, ival_we, expire;
  logic [N_TMR-1:0] ier_q, pend_q, pend_clr;

  itv_ctrl_t        ctrl [N_TMR];
  logic [CNT_W-1:0] ival [N_TMR];
  logic [CNT_W-1:0] cnt  [N_TMR];

  assign blk     = addr_i[ADDR_W-1:4];
  assign sub     = addr_i[3:2];
  assign word_ok = (addr_i[1:0] == 2'b00);
  assign glb_wr  = wr_en_i && word_ok && (blk == '0);

  for (genvar g = 0; g < N_TMR; g++) begin : gen_ch
    assign ctrl_we[g] = wr_en_i && word_ok && (blk == BLK_W'(g + 1)) && (sub == SUB_CTRL);
    assign ival_we[g] = wr_en_i && word_ok && (blk == BLK_W'(g + 1)) && (sub == SUB_IVAL);

    itv_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctrl_we_i(ctrl_we[g]),
      .ival_we_i(ival_we[g]),
      .wdata_i  (wdata_i),
      .ctrl_o   (ctrl[g]),
      .ival_o   (ival[g]),
      .cnt_o    (cnt[g]),
      .expire_o (expire[g])
    );
  end

  assign pend_clr = (glb_wr && sub == GLB_PEND) ? wdata_i[N_TMR-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ier_q <= '0;
    else if (glb_wr && sub == GLB_IER)   ier_q <= wdata_i[N_TMR-1:0];
  end

  // a fresh expiry overrides a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~pend_clr) | expire;
  end

  assign irq_o = |(pend_q & ier_q);

  always_comb begin
    rdata_o = '0;
    if (word_ok) begin
      if (blk == '0) begin
        if (sub == GLB_IER)       rdata_o = DATA_W'(ier_q);
        else if (sub == GLB_PEND) rdata_o = DATA_W'(pend_q);
      end
      for (int k = 0; k < N_TMR; k++) begin
        if (blk == BLK_W'(k + 1)) begin
          case (sub)
            SUB_CTRL: rdata_o = DATA_W'({ctrl[k].single, ctrl[k].psc, 3'b000, ctrl[k].en});
            SUB_IVAL: rdata_o = DATA_W'(ival[k]);
            SUB_CNT:  rdata_o = DATA_W'(cnt[k]);
            default:  rdata_o = '0;
          endcase
        end
      end
    end
  end

  assert_pend_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_wr && sub == GLB_PEND) |=>
      ((pend_q & $past(wdata_i[N_TMR-1:0]) & ~$past(expire)) == '0));

  assert_expire_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|expire) |=> ((pend_q & $past(expire)) == $past(expire)));

  assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ier_q != '0 && pend_q != '0));

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_o && pend_q == '0));
endmodule

// File: tb/test_multi_interval_timer.sv
`timescale 1ns/1ps
module test_multi_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  multi_interval_timer i_multi_interval_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  bit          m_en[4];
  bit          m_single[4];
  int unsigned m_psc[4], m_pre[4], m_cnt[4], m_ival[4];
  int unsigned m_pend, m_ier;

  function automatic int unsigned mread(logic [7:0] a);
    if (a == 8'h00) return m_ier;
    if (a == 8'h04) return m_pend;
    for (int k = 0; k < 4; k++) begin
      if (a == 8'(16 + 16*k)) return (int'(m_single[k]) << 7) | (m_psc[k] << 4) | int'(m_en[k]);
      if (a == 8'(20 + 16*k)) return m_ival[k];
      if (a == 8'(24 + 16*k)) return m_cnt[k];
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int unsigned div, expm;
    bit tick, restart, wctl;
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_en[k] = 0; m_single[k] = 0; m_psc[k] = 0; m_pre[k] = 0; m_cnt[k] = 0; m_ival[k] = 0;
      end
      m_pend = 0; m_ier = 0;
    end else begin
      expm = 0;
      for (int k = 0; k < 4; k++) begin
        div     = 1 << ((m_psc[k] > 4) ? 4 : m_psc[k]);
        tick    = m_en[k] && (m_pre[k] == div - 1);
        wctl    = wr_en && (addr == 8'(16 + 16*k));
        restart = wctl && ((wdata[0] && !m_en[k]) || (int'(wdata[6:4]) != m_psc[k]));
        if (tick && m_cnt[k] == 1) expm |= (1 << k);
        m_pre[k] = (restart || !m_en[k] || tick) ? 0 : m_pre[k] + 1;
        if (wctl && wdata[1]) m_cnt[k] = m_ival[k];
        else if (tick)        m_cnt[k] = (m_cnt[k] == 0) ? m_ival[k] : m_cnt[k] - 1;
        if (wctl) begin
          m_en[k] = wdata[0]; m_psc[k] = wdata[6:4]; m_single[k] = wdata[7];
        end else if (expm[k] && m_single[k]) m_en[k] = 0;
        if (wr_en && addr == 8'(20 + 16*k)) m_ival[k] = wdata;
      end
      if (wr_en && addr == 8'h04) m_pend = m_pend & ~(wdata & 32'hF);
      m_pend = m_pend | expm;
      if (wr_en && addr == 8'h00) m_ier = wdata & 32'hF;
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) check("R1", {31'b0, irq}, 32'h0);
      else begin
        check(cur_req, rdata, mread(addr));
        check(cur_req, {31'b0, irq}, {31'b0, (m_pend & m_ier) != 0});
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, logic [31:0] exp, string req);
    addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(100000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog (R1..): run did not complete");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(1);

    cur_req = "R1";
    peek(8'h00, 0, "R1"); peek(8'h04, 0, "R1");
    for (int k = 0; k < 4; k++) begin
      idle(1);
      peek(8'(16 + 16*k), 0, "R1"); peek(8'(20 + 16*k), 0, "R1");
      idle(1);
      peek(8'(24 + 16*k), 0, "R1");
    end
    check("R1", {31'b0, irq}, 0);

    // continuous divide-by-one, interval 5
    cur_req = "R2";
    wr(8'h00, 32'hF);
    wr(8'h14, 5);
    wr(8'h10, 32'h03);
    idle(2); peek(8'h18, 3, "R2");
    idle(3); peek(8'h18, 0, "R5"); peek(8'h04, 1, "R5");
    check("R8", {31'b0, irq}, 1);
    idle(1); peek(8'h18, 5, "R4");
    cur_req = "R7";
    wr(8'h04, 32'h0); peek(8'h04, 1, "R7");
    wr(8'h10, 32'h0);
    wr(8'h04, 32'h1); peek(8'h04, 0, "R7");
    check("R8", {31'b0, irq}, 0);

    // single mode, divide-by-four
    cur_req = "R6";
    wr(8'h24, 3);
    wr(8'h20, 32'hA3);
    peek(8'h20, 32'hA1, "R9"); peek(8'h28, 3, "R9");
    idle(4); peek(8'h28, 2, "R3");
    idle(8); peek(8'h28, 0, "R6"); peek(8'h20, 32'hA0, "R6");
    peek(8'h04, 32'h2, "R5");
    idle(5); peek(8'h28, 0, "R6");
    wr(8'h04, 32'h2);

    // code 7 behaves as divide-by-sixteen
    cur_req = "R3";
    wr(8'h34, 2);
    wr(8'h30, 32'h73);
    idle(15); peek(8'h38, 2, "R3");
    idle(1);  peek(8'h38, 1, "R3");
    wr(8'h30, 32'h70);

    // prescale change mid-period restarts the divider
    cur_req = "R10";
    wr(8'h44, 9);
    wr(8'h40, 32'h33);
    idle(5);
    wr(8'h40, 32'h21);
    idle(3); peek(8'h48, 9, "R10");
    idle(1); peek(8'h48, 8, "R10");

    // count register is read-only
    cur_req = "R11";
    wr(8'h40, 32'h20);
    addr = 8'h48; #1; held = rdata;
    wr(8'h48, 32'h55);
    peek(8'h48, held, "R11");

    // clear coinciding with expiry
    cur_req = "R7";
    wr(8'h14, 2);
    wr(8'h10, 32'h03);
    wr_en = 1'b1; addr = 8'h04; wdata = 32'h1;
    @(posedge clk); #2; peek(8'h04, 0, "R7");
    @(posedge clk); #2; peek(8'h04, 1, "R7");
    @(posedge clk); #2; peek(8'h04, 0, "R7");
    repeat (30) begin @(posedge clk); #2; end
    wr_en = 1'b0;

    // enable mask gates the interrupt
    cur_req = "R8";
    wr(8'h00, 32'h0);
    idle(6);
    check("R8", {31'b0, irq}, 0);
    addr = 8'h04; #1; check("R5", rdata & 32'h1, 1);
    wr(8'h00, 32'h1); #1;
    check("R8", {31'b0, irq}, 1);
    wr(8'h10, 32'h0);
    wr(8'h04, 32'hF);

    // mixed run with sporadic clears
    cur_req = "R4";
    wr(8'h00, 32'hF);
    wr(8'h14, 4);  wr(8'h10, 32'h13);
    wr(8'h24, 7);  wr(8'h20, 32'h03);
    wr(8'h34, 1);  wr(8'h30, 32'h23);
    wr(8'h44, 3);  wr(8'h40, 32'h53);
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 5) == 0) wr(8'h04, 32'($urandom_range(0, 15)));
      else begin addr = 8'(16 + 16*$urandom_range(0, 3) + 8); idle(1); end
    end
    idle(2);
    finish_run();
  end
endmodule